// File: doc/BRIEF.md
# Read Burst Column Sequencer

This block produces the column addresses of a read burst in a synchronous DRAM device model and times the two strobes that go with them. A registered READ command gives a starting column. Stored mode settings say how many beats follow (2, 4 or 8), which order they take, and how many clocks separate the command from the first valid beat (2 or 3). Each beat's column is shown on `out_col` while `out_valid` is high. `out_oe` rises one clock ahead of the first valid beat, as an output driver would.

Two orderings are supported. In wrapping order the burst counts upward and wraps inside its aligned block. In interleaved order the beat index is XORed into the starting position. Only the low column bits that the burst length selects take part; all higher bits stay as given. The mode settings are written through a load strobe. A load is taken only while no burst is in flight. A load with a reserved code raises a sticky error, and reads are refused until a clean load clears it. A READ that arrives during a burst cuts the old burst short and starts the new one.

The block suits a memory model's read path, or an expected-data checker in a controller test environment.

Top module: `burst_seq`

## Requirements
- R1: After reset `out_oe`, `out_valid` and `mode_err` are 0, and the mode is 4 beats, wrapping order, latency 2.
- R2: While `out_valid` is 0, `out_col` is 0. During a burst, the column bits above the burst field keep the starting value. The field is bit 0 for 2 beats, bits 1:0 for 4 beats and bits 2:0 for 8 beats.
- R3: In wrapping order (`mode_ilv`=0), beat k's field equals (start field + k) modulo the burst length.
- R4: In interleaved order (`mode_ilv`=1), beat k's field equals the start field XOR k.
- R5: A READ sampled at edge n with latency m gives `out_valid`=1 first for the cycle that ends at edge n+m, so it is seen at that edge. `out_oe` is 1 from one cycle earlier. Both strobes go low in the cycle after the last beat.
- R6: The burst length code `mode_blen` gives 2^code beats: 1 gives 2 beats, 2 gives 4 beats, 3 gives 8 beats. `out_valid` stays high for exactly that many consecutive cycles.
- R7: The latency code `mode_lat` of 2 or 3 is the latency in clocks.
- R8: `mode_blen`=0 or `mode_lat` of 0 or 1 is reserved. Loading one sets `mode_err` and leaves the old settings. While `mode_err` is 1, READs give no strobes. A load with valid codes clears `mode_err`.
- R9: A mode load is ignored while a burst is pending or beating. A load that is taken drops a READ in the same cycle.
- R10: A READ during a burst ends the old burst at once. The new burst follows at the programmed latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_load | input | 1 | Write the mode settings |
| mode_blen | input | 2 | Burst length code, log2 of beats |
| mode_ilv | input | 1 | 1 = interleaved order, 0 = wrapping order |
| mode_lat | input | 2 | Read latency in clocks |
| rd_cmd | input | 1 | READ command strobe |
| rd_col | input | COL_W | Starting column of the READ |
| out_col | output | COL_W | Column of the current beat |
| out_oe | output | 1 | Output drive enable |
| out_valid | output | 1 | Beat data valid |
| mode_err | output | 1 | Sticky reserved-code error |

## Verification
A wrong beat counter or wrong order select shows on `out_col` in the second beat of the burst, one clock after the first valid beat. A wrong latency count moves the rising edge of `out_valid` or `out_oe` in the first cycle it matters. A bad mode state, such as a missed error or a load taken while busy, shows on `mode_err` right after the load edge, or in the shape of the next burst. The sweep covers every start offset under every length, order and latency, so each such fault appears within one burst of its cause.

// File: rtl/burst_seq_pkg.sv
`timescale 1ns/1ps
package burst_seq_pkg;
   localparam int CODE_W = 2;

   typedef struct packed {
      logic [CODE_W-1:0] bl_log;
      logic              ilv;
      logic [CODE_W-1:0] lat;
   } mode_t;

   function automatic logic code_bad(input logic [CODE_W-1:0] blc,
                                     input logic [CODE_W-1:0] latc,
                                     input int              bl_max);
      return (blc == '0) || (int'(blc) > bl_max) || (latc < 2'd2);
   endfunction
endpackage

// File: rtl/burst_seq_mode.sv
`timescale 1ns/1ps
module burst_seq_mode
   import burst_seq_pkg::*;
#(
   parameter int BL_LOG_MAX = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              busy,
   input  logic [CODE_W-1:0] blen_code,
   input  logic              ilv_in,
   input  logic [CODE_W-1:0] lat_code,
   output mode_t             mode,
   output logic              err,
   output logic              taken
);
   localparam int DEF_LOG = (BL_LOG_MAX < 2) ? BL_LOG_MAX : 2;

   logic bad;

   assign taken = load && !busy;
   assign bad   = code_bad(blen_code, lat_code, BL_LOG_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode.bl_log <= CODE_W'(DEF_LOG);
         mode.ilv    <= 1'b0;
         mode.lat    <= CODE_W'(2);
         err         <= 1'b0;
      end else if (taken) begin
         err <= bad;
         if (!bad) begin
            mode.bl_log <= blen_code;
            mode.ilv    <= ilv_in;
            mode.lat    <= lat_code;
         end
      end
   end
endmodule

// File: rtl/burst_seq_ctl.sv
`timescale 1ns/1ps
module burst_seq_ctl
   import burst_seq_pkg::*;
#(
   parameter int LOW_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [CODE_W-1:0] lat,
   input  logic [CODE_W-1:0] bl_log,
   output logic [LOW_W-1:0]  idx,
   output logic              oe,
   output logic              valid,
   output logic              busy
);
   logic              pend;
   logic              run;
   logic [CODE_W-1:0] wait_cnt;
   logic [LOW_W-1:0]  last_idx;

   assign last_idx = LOW_W'((1 << bl_log) - 1);
   assign busy     = pend || run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend     <= 1'b0;
         run      <= 1'b0;
         wait_cnt <= '0;
         idx      <= '0;
         oe       <= 1'b0;
         valid    <= 1'b0;
      end else if (go) begin
         pend     <= 1'b1;
         run      <= 1'b0;
         wait_cnt <= lat - 1'b1;
         idx      <= '0;
         valid    <= 1'b0;
         oe       <= (lat == CODE_W'(2));
      end else if (pend) begin
         if (wait_cnt == CODE_W'(1)) begin
            pend  <= 1'b0;
            run   <= 1'b1;
            valid <= 1'b1;
            oe    <= 1'b1;
            idx   <= '0;
         end else begin
            wait_cnt <= wait_cnt - 1'b1;
            oe       <= (wait_cnt == CODE_W'(2));
         end
      end else if (run) begin
         if (idx == last_idx) begin
            run   <= 1'b0;
            valid <= 1'b0;
            oe    <= 1'b0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/burst_seq_addr.sv
`timescale 1ns/1ps
module burst_seq_addr
   import burst_seq_pkg::*;
#(
   parameter int COL_W = 9,
   parameter int LOW_W = 3
) (
   input  logic [COL_W-1:0]  start,
   input  logic [LOW_W-1:0]  idx,
   input  logic [CODE_W-1:0] bl_log,
   input  logic              ilv,
   output logic [COL_W-1:0]  col
);
   logic [LOW_W-1:0] wrap_sum;

   assign wrap_sum = start[LOW_W-1:0] + idx;

   for (genvar i = 0; i < LOW_W; i++) begin : g_low
      logic in_field;
      assign in_field = (i < int'(bl_log));
      assign col[i]   = !in_field ? start[i] :
                        ilv       ? (start[i] ^ idx[i]) : wrap_sum[i];
   end

   if (COL_W > LOW_W) begin : g_high
      assign col[COL_W-1:LOW_W] = start[COL_W-1:LOW_W];
   end
endmodule

// File: rtl/burst_seq.sv
`timescale 1ns/1ps
module burst_seq
   import burst_seq_pkg::*;
#(
   parameter int COL_W      = 9,
   parameter int BL_LOG_MAX = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_load,
   input  logic [1:0]       mode_blen,
   input  logic             mode_ilv,
   input  logic [1:0]       mode_lat,
   input  logic             rd_cmd,
   input  logic [COL_W-1:0] rd_col,
   output logic [COL_W-1:0] out_col,
   output logic             out_oe,
   output logic             out_valid,
   output logic             mode_err
);
   localparam int LOW_W = BL_LOG_MAX;

   if (BL_LOG_MAX < 1 || BL_LOG_MAX > 3) begin : g_bad_bl
      $error("burst_seq: BL_LOG_MAX must be 1..3");
   end
   if (COL_W < LOW_W) begin : g_bad_col
      $error("burst_seq: COL_W narrower than burst field");
   end

   mode_t             mode;
   logic              busy;
   logic              load_taken;
   logic              go;
   logic [LOW_W-1:0]  idx;
   logic [COL_W-1:0]  cap_start;
   logic [CODE_W-1:0] cap_bl_log;
   logic              cap_ilv;
   logic [COL_W-1:0]  beat_col;

   burst_seq_mode #(.BL_LOG_MAX(BL_LOG_MAX)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (mode_load),
      .busy      (busy),
      .blen_code (mode_blen),
      .ilv_in    (mode_ilv),
      .lat_code  (mode_lat),
      .mode      (mode),
      .err       (mode_err),
      .taken     (load_taken)
   );

   assign go = rd_cmd && !mode_err && !load_taken;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_start  <= '0;
         cap_bl_log <= '0;
         cap_ilv    <= 1'b0;
      end else if (go) begin
         cap_start  <= rd_col;
         cap_bl_log <= mode.bl_log;
         cap_ilv    <= mode.ilv;
      end
   end

   burst_seq_ctl #(.LOW_W(LOW_W)) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (go),
      .lat    (mode.lat),
      .bl_log (go ? mode.bl_log : cap_bl_log),
      .idx    (idx),
      .oe     (out_oe),
      .valid  (out_valid),
      .busy   (busy)
   );

   burst_seq_addr #(.COL_W(COL_W), .LOW_W(LOW_W)) u_addr (
      .start  (cap_start),
      .idx    (idx),
      .bl_log (cap_bl_log),
      .ilv    (cap_ilv),
      .col    (beat_col)
   );

   assign out_col = out_valid ? beat_col : '0;
endmodule

// File: rtl/burst_seq_chk.sv
`timescale 1ns/1ps
module burst_seq_chk #(
   parameter int COL_W = 9,
   parameter int LOW_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [COL_W-1:0] out_col,
   input logic             out_oe,
   input logic             out_valid,
   input logic             mode_err,
   input logic [1:0]       bl_log,
   input logic             ilv
);
   logic [3:0]       run_cnt;
   logic [LOW_W-1:0] fmask;

   assign fmask = LOW_W'((1 << bl_log) - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_cnt <= '0;
      else        run_cnt <= out_valid ? run_cnt + 1'b1 : '0;
   end

   AST_VALID_HAS_OE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_oe); // R5
   AST_OE_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(out_oe)); // R5
   AST_IDLE_COL: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_col == '0)); // R2
   AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |->
         (out_col[COL_W-1:LOW_W] == $past(out_col[COL_W-1:LOW_W]))); // R2
   AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid) && !ilv) |->
         (((out_col[LOW_W-1:0] ^ ($past(out_col[LOW_W-1:0]) + 1'b1)) & fmask) == '0)); // R3
   AST_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(run_cnt) < (1 << bl_log))); // R6
   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> (!out_valid && !out_oe)); // R8
endmodule

bind burst_seq burst_seq_chk #(.COL_W(COL_W), .LOW_W(LOW_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_col   (out_col),
   .out_oe    (out_oe),
   .out_valid (out_valid),
   .mode_err  (mode_err),
   .bl_log    (cap_bl_log),
   .ilv       (cap_ilv)
);

// File: tb/burst_seq_test.sv
`timescale 1ns/1ps
module burst_seq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_load = 1'b0;
   logic [1:0] mode_blen = 2'd0;
   logic       mode_ilv = 1'b0;
   logic [1:0] mode_lat = 2'd0;
   logic       rd_cmd = 1'b0;
   logic [8:0] rd_col = '0;
   logic [8:0] out_col;
   logic       out_oe, out_valid, mode_err;

   always #2.5 clk = ~clk;

   burst_seq uut (.*);

   int vectors = 0, misses = 0, cyc = 0, busy_end = -1;
   bit done = 0;
   logic       r_oe  [64];
   logic       r_val [64];
   logic [8:0] r_col [64];
   int m_bl = 4, m_lat = 2;
   logic m_ilv = 0, m_err = 0;
   string tag_tim = "R1", tag_col = "R1", tag_err = "R1";

   task automatic cmp(string req, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         misses++;
         $display("FAIL %s %s got %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      cyc++;
      #1;
      cmp(tag_tim, "valid", out_valid, r_val[cyc%64]);
      cmp(tag_tim, "oe", out_oe, r_oe[cyc%64]);
      cmp(tag_col, "col", out_col, r_val[cyc%64] ? r_col[cyc%64] : 9'd0);
      cmp(tag_err, "err", mode_err, m_err);
      r_val[cyc%64] = 0; r_oe[cyc%64] = 0; r_col[cyc%64] = 0;
   endtask

   function automatic logic [8:0] exp_col(logic [8:0] s, int k, int bl, logic il);
      int msk = bl - 1;
      int lo  = il ? ((s & 7) ^ k) & msk : ((s & 7) + k) & msk;
      return 9'((int'(s) & ~msk) | lo);
   endfunction

   task automatic sched(logic [8:0] c);
      int e = cyc + 1;
      if (m_err) return;
      for (int t = e; t < e + 16; t++) begin
         r_val[t%64] = 0; r_oe[t%64] = 0; r_col[t%64] = 0;
      end
      r_oe[(e+m_lat-2)%64] = 1;
      for (int k = 0; k < m_bl; k++) begin
         r_val[(e+m_lat-1+k)%64] = 1;
         r_oe[(e+m_lat-1+k)%64]  = 1;
         r_col[(e+m_lat-1+k)%64] = exp_col(c, k, m_bl, m_ilv);
      end
      busy_end = e + m_lat + m_bl - 1;
   endtask

   function automatic bit model_load(logic [1:0] b, logic il, logic [1:0] l);
      if (cyc + 1 <= busy_end) return 0;
      if (b == 0 || l < 2) m_err = 1;
      else begin m_err = 0; m_bl = 1 << b; m_ilv = il; m_lat = l; end
      return 1;
   endfunction

   task automatic do_load(logic [1:0] b, logic il, logic [1:0] l);
      bit tk;
      mode_load = 1; mode_blen = b; mode_ilv = il; mode_lat = l;
      tk = model_load(b, il, l);
      tick();
      mode_load = 0;
   endtask

   task automatic do_read(logic [8:0] c);
      rd_cmd = 1; rd_col = c;
      sched(c);
      tick();
      rd_cmd = 0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         misses++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) begin r_oe[i] = 0; r_val[i] = 0; r_col[i] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: quiet after reset, then default mode (4 beats, wrapping, latency 2)
      tag_tim = "R1"; tag_col = "R1"; tag_err = "R1";
      idle(2);
      do_read(9'h1F6);
      idle(6);

      // Sweep: latency x order x length x start offset
      for (int l = 2; l <= 3; l++)
         for (int il = 0; il <= 1; il++)
            for (int b = 1; b <= 3; b++)
               for (int s = 0; s < 8; s++) begin
                  logic [8:0] c = 9'(((s * 37 + b * 11) & 63) << 3 | s);
                  tag_tim = (l == 3) ? "R7" : (b == 3) ? "R6" : "R5";
                  tag_col = il ? "R4" : ((s & 1) ? "R2" : "R3");
                  tag_err = "R9";
                  do_load(2'(b), 1'(il), 2'(l));
                  do_read(c);
                  idle(l + (1 << b) + 1);
               end

      // R10: truncation, wrapping order, latency 3
      tag_tim = "R10"; tag_col = "R10"; tag_err = "R10";
      do_load(2'd3, 1'b0, 2'd3);
      do_read(9'h000);
      idle(4);
      do_read(9'h105);
      idle(12);
      // R10: truncation, interleaved order, latency 2
      do_load(2'd2, 1'b1, 2'd2);
      do_read(9'h0A2);
      idle(2);
      do_read(9'h1C7);
      idle(8);

      // R9: loads while busy are ignored; a taken load drops a same-cycle read
      tag_tim = "R9"; tag_col = "R9"; tag_err = "R9";
      do_load(2'd3, 1'b0, 2'd3);
      do_read(9'h033);
      do_load(2'd1, 1'b1, 2'd2);
      idle(3);
      do_load(2'd0, 1'b0, 2'd2);
      idle(8);
      do_read(9'h04C);
      idle(12);
      mode_load = 1; mode_blen = 2'd1; mode_ilv = 1'b0; mode_lat = 2'd2;
      rd_cmd = 1; rd_col = 9'h011;
      begin bit tk; tk = model_load(2'd1, 1'b0, 2'd2); end
      tick();
      mode_load = 0; rd_cmd = 0;
      idle(4);

      // R8: reserved codes set a sticky error and block reads
      tag_tim = "R8"; tag_col = "R8"; tag_err = "R8";
      do_load(2'd0, 1'b0, 2'd2);
      do_read(9'h012);
      idle(6);
      do_load(2'd2, 1'b0, 2'd1);
      do_read(9'h013);
      idle(6);
      do_load(2'd2, 1'b1, 2'd0);
      idle(2);
      do_load(2'd2, 1'b1, 2'd3);
      do_read(9'h0F9);
      idle(8);

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule